// File: doc/BRIEF.md
# Time interval counter

This block keeps elapsed time from a 32.768 kHz tick. A prescaler turns the tick into 1/128-second steps. Four cascaded digit counters hold the elapsed fraction, seconds, minutes and hours, and each one carries into the next when it wraps. Software can write all four digits at any time.

An interval alarm runs alongside the clock. It counts events of one chosen unit: a fraction step, or a wrap of the fraction, seconds or minutes digit. When the count reaches the programmed 8-bit interval, it raises a sticky interrupt flag. In auto-reload mode the count then starts again from zero. In one-shot mode it stops until the alarm is disabled and enabled again.

All registers are written through one select/data port and read back in parallel. The interrupt flag is also driven on its own output.

Top module: `tic_core`

## Requirements
- R1: After reset the control register reads 0x40, and the interval, fraction, seconds, minutes and hours registers and `irq_o` all read 0.
- R2: While the clock-enable bit is 1, every PRESCALE ticks on `tick_i` advance the fraction register by one. A cycle without a tick changes nothing. The register updates on the clock edge that samples the PRESCALE-th tick.
- R3: The fraction register wraps from FRAC_MOD-1 to 0 and carries into seconds. Seconds wrap at SEC_MOD and carry into minutes. Minutes wrap at MIN_MOD and carry into hours. Hours wrap from HOUR_MOD-1 to 0.
- R4: While the clock-enable bit (control bit 0) is 0, ticks are ignored. The prescaler phase and all four time registers hold their values.
- R5: A write with `wr_en_i` high loads the register chosen by `wr_sel_i`: 0 control, 1 interval, 2 fraction, 3 seconds, 4 minutes, 5 hours. Codes 6 and 7 change nothing. A write to a time digit takes priority over an increment in the same cycle. A value at or above that digit's modulus is stored as 0.
- R6: The control register has these fields: bit 0 clock enable, bit 1 interval enable, bit 2 interrupt flag, bit 3 one-shot select, bits 5:4 unit, bit 6 always reads 1, bit 7 always reads 0.
- R7: The unit field selects what the alarm counts: 0 counts fraction steps, 1 counts fraction wraps (seconds), 2 counts seconds wraps (minutes), 3 counts minutes wraps (hours). The flag rises on the edge of the N-th counted event after the alarm is enabled, where N is the interval register. An interval of 0 means 256 events.
- R8: With the one-shot bit at 0, the alarm count restarts at zero after each match, and the flag is raised again after every further N events.
- R9: With the one-shot bit at 1, the alarm stops after its first match and raises no further flag until the interval enable is cleared.
- R10: While the interval enable bit is 0, the alarm count is held at zero. Enabling it again restarts the count from zero.
- R11: The flag stays set until a control write with bit 2 at 0 clears it. Writing bit 2 as 1 never sets the flag. A match in the same cycle as a clearing write leaves the flag set.
- R12: `irq_o` always equals control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per 32.768 kHz period |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for writes |
| wr_data_i | input | REG_W | Write data |
| ctl_o | output | 8 | Control register readback |
| interval_o | output | REG_W | Interval register readback |
| frac_o | output | REG_W | Elapsed 1/128 seconds |
| sec_o | output | REG_W | Elapsed seconds |
| min_o | output | REG_W | Elapsed minutes |
| hour_o | output | REG_W | Elapsed hours |
| irq_o | output | 1 | Interval interrupt flag |

## Verification
The bench builds the block with PRESCALE set to 4 instead of 256 and keeps the default digit moduli and an 8-bit register width. The short prescaler makes a full fraction wrap take 512 ticks, so fraction-unit alarms, including the 256-event case behind an interval of 0, fit in a few thousand cycles. Minute, hour and day rollovers, and the minute- and hour-unit alarm events, are reached by preloading the digits to one step before their carry point.

// File: rtl/tic_pkg.sv
package tic_pkg;

   localparam int unsigned TIC_DIGITS = 4;

   typedef enum logic [1:0] {
      UNIT_FRAC = 2'd0,
      UNIT_SEC  = 2'd1,
      UNIT_MIN  = 2'd2,
      UNIT_HOUR = 2'd3
   } tic_unit_e;

   typedef enum logic [2:0] {
      SEL_CTL  = 3'd0,
      SEL_IVAL = 3'd1,
      SEL_FRAC = 3'd2,
      SEL_SEC  = 3'd3,
      SEL_MIN  = 3'd4,
      SEL_HOUR = 3'd5
   } tic_sel_e;

   typedef struct packed {
      logic      zero7;
      logic      one6;
      tic_unit_e unit;
      logic      oneshot;
      logic      flag;
      logic      ien;
      logic      cen;
   } tic_ctl_t;

   localparam int unsigned CTL_CEN  = 0;
   localparam int unsigned CTL_IEN  = 1;
   localparam int unsigned CTL_FLAG = 2;
   localparam int unsigned CTL_OS   = 3;
   localparam int unsigned CTL_UNIT = 4;

endpackage

// File: rtl/tic_prescale.sv
module tic_prescale #(
   parameter int unsigned DIV = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   output logic step_o
);

   localparam int unsigned CW       = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit          DIV_POW2 = (DIV == (1 << CW));

   generate
      if (DIV < 2) begin : g_bad_div
         $error("tic_prescale: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          adv;

   assign adv = run_i & tick_i;

   generate
      if (DIV_POW2) begin : g_pow2
         // free-running binary counter, step on all-ones
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (adv) cnt_q <= cnt_q + 1'b1;
         end
         assign step_o = adv & (&cnt_q);
      end else begin : g_modulo
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (adv) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
         assign step_o = adv & (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/tic_digit.sv
module tic_digit #(
   parameter int unsigned MOD = 60,
   parameter int unsigned W   = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   output logic [W-1:0] val_o
);

   generate
      if (MOD < 2 || MOD > (1 << W)) begin : g_bad_mod
         $error("tic_digit: MOD must lie in 2 .. 2**W");
      end
   endgenerate

   localparam logic [W-1:0] TOP = W'(MOD - 1);

   logic [W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q <= '0;
      end else if (ld_i) begin
         val_q <= (ld_val_i > TOP) ? '0 : ld_val_i;
      end else if (inc_i) begin
         val_q <= (val_q == TOP) ? '0 : val_q + 1'b1;
      end
   end

   assign val_o = val_q;

endmodule

// File: rtl/tic_alarm.sv
module tic_alarm #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          oneshot_i,
   input  logic [CW-1:0] ival_i,
   input  logic          event_i,
   input  logic          clr_i,
   output logic          flag_o,
   output logic [CW-1:0] cnt_o
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          done_q;
   logic          flag_q;
   logic          live;
   logic          hit;

   assign cnt_nxt = cnt_q + 1'b1;
   assign live    = en_i & event_i & ~done_q;
   // wrap of cnt_nxt to zero makes an interval of 0 span 2**CW events
   assign hit     = live & (cnt_nxt == ival_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!en_i) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (hit) begin
         cnt_q  <= oneshot_i ? cnt_nxt : '0;
         done_q <= oneshot_i;
      end else if (live) begin
         cnt_q  <= cnt_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (hit)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/tic_core.sv
module tic_core
   import tic_pkg::*;
#(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned PRESCALE = 256,
   parameter int unsigned FRAC_MOD = 128,
   parameter int unsigned SEC_MOD  = 60,
   parameter int unsigned MIN_MOD  = 60,
   parameter int unsigned HOUR_MOD = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_sel_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [7:0]       ctl_o,
   output logic [REG_W-1:0] interval_o,
   output logic [REG_W-1:0] frac_o,
   output logic [REG_W-1:0] sec_o,
   output logic [REG_W-1:0] min_o,
   output logic [REG_W-1:0] hour_o,
   output logic             irq_o
);

   localparam int unsigned DIG_MOD [TIC_DIGITS] = '{FRAC_MOD, SEC_MOD, MIN_MOD, HOUR_MOD};

   generate
      if (REG_W < 8 || REG_W > 16) begin : g_bad_width
         $error("tic_core: REG_W must lie in 8 .. 16");
      end
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("tic_core: PRESCALE must be at least 2");
      end
   endgenerate

   // control fields
   logic       cen_q;
   logic       ien_q;
   logic       os_q;
   tic_unit_e  unit_q;
   logic [REG_W-1:0] ival_q;
   logic       ctl_wr;
   logic       ival_wr;

   assign ctl_wr  = wr_en_i && (wr_sel_i == SEL_CTL);
   assign ival_wr = wr_en_i && (wr_sel_i == SEL_IVAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cen_q  <= 1'b0;
         ien_q  <= 1'b0;
         os_q   <= 1'b0;
         unit_q <= UNIT_FRAC;
      end else if (ctl_wr) begin
         cen_q  <= wr_data_i[CTL_CEN];
         ien_q  <= wr_data_i[CTL_IEN];
         os_q   <= wr_data_i[CTL_OS];
         unit_q <= tic_unit_e'(wr_data_i[CTL_UNIT +: 2]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ival_q <= '0;
      else if (ival_wr) ival_q <= wr_data_i;
   end

   // prescaler: ticks to 1/128-second steps
   logic step;

   tic_prescale #(.DIV(PRESCALE)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (cen_q),
      .tick_i (tick_i),
      .step_o (step)
   );

   // digit chain; inc[i] is the advance strobe of digit i
   logic [TIC_DIGITS-1:0] inc;
   logic [REG_W-1:0]      dval [TIC_DIGITS];

   assign inc[0] = step;

   generate
      for (genvar i = 0; i < TIC_DIGITS; i++) begin : g_dig
         logic ld;
         assign ld = wr_en_i && (wr_sel_i == 3'(int'(SEL_FRAC) + i));

         tic_digit #(.MOD(DIG_MOD[i]), .W(REG_W)) u_digit (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (inc[i]),
            .ld_i     (ld),
            .ld_val_i (wr_data_i),
            .val_o    (dval[i])
         );

         if (i < TIC_DIGITS - 1) begin : g_carry
            assign inc[i+1] = inc[i] && (dval[i] == REG_W'(DIG_MOD[i] - 1));
         end
      end
   endgenerate

   // interval alarm
   logic             unit_evt;
   logic             flag;
   logic [REG_W-1:0] alarm_cnt;

   assign unit_evt = inc[unit_q];

   tic_alarm #(.CW(REG_W)) u_alarm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (ien_q),
      .oneshot_i (os_q),
      .ival_i    (ival_q),
      .event_i   (unit_evt),
      .clr_i     (ctl_wr && !wr_data_i[CTL_FLAG]),
      .flag_o    (flag),
      .cnt_o     (alarm_cnt)
   );

   tic_ctl_t ctl_rd;

   always_comb begin
      ctl_rd         = '0;
      ctl_rd.zero7   = 1'b0;
      ctl_rd.one6    = 1'b1;
      ctl_rd.unit    = unit_q;
      ctl_rd.oneshot = os_q;
      ctl_rd.flag    = flag;
      ctl_rd.ien     = ien_q;
      ctl_rd.cen     = cen_q;
   end

   assign ctl_o      = ctl_rd;
   assign interval_o = ival_q;
   assign frac_o     = dval[0];
   assign sec_o      = dval[1];
   assign min_o      = dval[2];
   assign hour_o     = dval[3];
   assign irq_o      = flag;

endmodule

// File: rtl/tic_core_checker.sv
module tic_core_checker #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned FRAC_MOD = 128,
   parameter int unsigned SEC_MOD  = 60,
   parameter int unsigned MIN_MOD  = 60,
   parameter int unsigned HOUR_MOD = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en_i,
   input logic [2:0]       wr_sel_i,
   input logic             wr_flag_bit,
   input logic             cen,
   input logic             ien,
   input logic [REG_W-1:0] frac_o,
   input logic [REG_W-1:0] sec_o,
   input logic [REG_W-1:0] min_o,
   input logic [REG_W-1:0] hour_o,
   input logic             irq_o,
   input logic [REG_W-1:0] alarm_cnt
);

   AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (frac_o < REG_W'(FRAC_MOD)) && (sec_o < REG_W'(SEC_MOD)) && (min_o < REG_W'(MIN_MOD)) && (hour_o < REG_W'(HOUR_MOD))); // R5

   AST_CLOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!cen && !wr_en_i) |=> ($stable(frac_o) && $stable(sec_o) && $stable(min_o) && $stable(hour_o))); // R4

   AST_FRAC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en_i) && ($past(frac_o) == REG_W'(FRAC_MOD - 1)) && (frac_o == '0)) |-> (sec_o != $past(sec_o))); // R3

   AST_ALARM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      !ien |=> (alarm_cnt == '0)); // R10

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(wr_en_i && (wr_sel_i == 3'd0) && !wr_flag_bit)) |=> irq_o); // R11

endmodule

bind tic_core tic_core_checker #(
   .REG_W    (REG_W),
   .FRAC_MOD (FRAC_MOD),
   .SEC_MOD  (SEC_MOD),
   .MIN_MOD  (MIN_MOD),
   .HOUR_MOD (HOUR_MOD)
) u_tic_core_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en_i     (wr_en_i),
   .wr_sel_i    (wr_sel_i),
   .wr_flag_bit (wr_data_i[2]),
   .cen         (cen_q),
   .ien         (ien_q),
   .frac_o      (frac_o),
   .sec_o       (sec_o),
   .min_o       (min_o),
   .hour_o      (hour_o),
   .irq_o       (irq_o),
   .alarm_cnt   (alarm_cnt)
);

// File: tb/tic_core_bench.sv
`timescale 1ns/100ps
module tic_core_bench;

   localparam int PS = 4;
   localparam int FM = 128;
   localparam int SM = 60;
   localparam int MM = 60;
   localparam int HM = 24;
   localparam int W  = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic         we = 1'b0;
   logic [2:0]   sel = 3'd0;
   logic [W-1:0] wd = '0;
   logic [7:0]   ctl_o;
   logic [W-1:0] interval_o, frac_o, sec_o, min_o, hour_o;
   logic         irq_o;

   always #2.5 clk = ~clk;

   tic_core #(.REG_W(W), .PRESCALE(PS)) u_tic_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .wr_en_i    (we),
      .wr_sel_i   (sel),
      .wr_data_i  (wd),
      .ctl_o      (ctl_o),
      .interval_o (interval_o),
      .frac_o     (frac_o),
      .sec_o      (sec_o),
      .min_o      (min_o),
      .hour_o     (hour_o),
      .irq_o      (irq_o)
   );

   int    total = 0;
   int    bad = 0;
   bit    over = 0;
   string phase = "R1";

   // reference state
   int m_pre = 0, m_frac = 0, m_sec = 0, m_min = 0, m_hour = 0;
   int m_ival = 0, m_cnt = 0, m_unit = 0;
   bit m_cen = 0, m_ien = 0, m_os = 0, m_done = 0, m_flag = 0;

   task automatic check(string tag, int act, int exp, string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_ctl();
      return 32'h40 | (m_unit << 4) | (int'(m_os) << 3) | (int'(m_flag) << 2) | (int'(m_ien) << 1) | int'(m_cen);
   endfunction

   task automatic model_cycle(bit t, bit w, int s, int d);
      bit stp, fw, sw, mw, ev, hit, clr;
      int nx;
      stp = t && m_cen && (m_pre == PS - 1);
      fw  = stp && (m_frac == FM - 1);
      sw  = fw && (m_sec == SM - 1);
      mw  = sw && (m_min == MM - 1);
      case (m_unit)
         0:       ev = stp;
         1:       ev = fw;
         2:       ev = sw;
         default: ev = mw;
      endcase
      hit = 0;
      if (!m_ien) begin
         m_cnt = 0; m_done = 0;
      end else if (ev && !m_done) begin
         nx = (m_cnt + 1) % 256;
         if (nx == m_ival) begin
            hit = 1; m_cnt = m_os ? nx : 0; m_done = m_os;
         end else begin
            m_cnt = nx;
         end
      end
      if (t && m_cen) m_pre = (m_pre == PS - 1) ? 0 : m_pre + 1;
      if (stp) m_frac = fw ? 0 : m_frac + 1;
      if (fw)  m_sec  = sw ? 0 : m_sec + 1;
      if (sw)  m_min  = mw ? 0 : m_min + 1;
      if (mw)  m_hour = (m_hour == HM - 1) ? 0 : m_hour + 1;
      clr = 0;
      if (w) begin
         case (s)
            0: begin
               clr = ((d >> 2) & 1) == 0;
               m_cen = d[0]; m_ien = d[1]; m_os = d[3]; m_unit = (d >> 4) & 3;
            end
            1: m_ival = d;
            2: m_frac = (d < FM) ? d : 0;
            3: m_sec  = (d < SM) ? d : 0;
            4: m_min  = (d < MM) ? d : 0;
            5: m_hour = (d < HM) ? d : 0;
            default: ;
         endcase
      end
      m_flag = hit || (m_flag && !clr);
   endtask

   task automatic compare_all();
      check(phase, int'(ctl_o), exp_ctl(), "ctl");
      check(phase, int'(interval_o), m_ival, "interval");
      check(phase, int'(frac_o), m_frac, "frac");
      check(phase, int'(sec_o), m_sec, "sec");
      check(phase, int'(min_o), m_min, "min");
      check(phase, int'(hour_o), m_hour, "hour");
      check("R12", int'(irq_o), int'(m_flag), "irq");
   endtask

   task automatic cyc(bit t, bit w, int s, int d);
      @(negedge clk);
      tick = t; we = w; sel = 3'(s); wd = W'(d);
      model_cycle(t, w, s, d);
      @(posedge clk);
      #1;
      compare_all();
      tick = 1'b0; we = 1'b0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
   endtask

   task automatic wr(int s, int d);
      cyc(0, 1, s, d);
   endtask

   initial begin
      #(200000 * 5);
      if (!over) begin
         over = 1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1;
      phase = "R1";
      check("R1", int'(ctl_o), 32'h40, "ctl at reset");
      check("R1", int'(frac_o) + int'(sec_o) + int'(min_o) + int'(hour_o) + int'(interval_o), 0, "regs at reset");
      check("R1", int'(irq_o), 0, "irq at reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R2: prescaler
      phase = "R2";
      wr(0, 8'h01);
      ticks(12);
      check("R2", int'(frac_o), 3, "frac after 12 ticks");
      for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0);
      check("R2", int'(frac_o), 3, "frac without ticks");

      // R4: clock disabled
      phase = "R4";
      wr(0, 8'h00);
      ticks(20);
      check("R4", int'(frac_o), 3, "frac while stopped");

      // R3: full rollover
      phase = "R3";
      wr(5, 23); wr(4, 59); wr(3, 59); wr(2, 127); wr(0, 8'h01);
      ticks(3);
      check("R3", int'(frac_o), 127, "frac before wrap");
      ticks(1);
      check("R3", int'(frac_o) + int'(sec_o) + int'(min_o) + int'(hour_o), 0, "all digits after day wrap");

      // R5: writes
      phase = "R5";
      wr(3, 61);
      check("R5", int'(sec_o), 0, "out-of-range sec");
      wr(3, 42);
      wr(6, 8'h11);
      wr(7, 8'h22);
      check("R5", int'(sec_o), 42, "sec after unused selects");
      check("R5", int'(ctl_o), 32'h41, "ctl after unused selects");
      ticks(3);
      cyc(1, 1, 2, 10);
      check("R5", int'(frac_o), 10, "write beats increment");

      // R7 / R6: fraction-unit alarm
      phase = "R7";
      wr(1, 3); wr(0, 8'h03);
      ticks(11);
      check("R7", int'(irq_o), 0, "irq before 3rd step");
      ticks(1);
      check("R7", int'(irq_o), 1, "irq at 3rd step");

      phase = "R11";
      wr(0, 8'h07);
      check("R11", int'(irq_o), 1, "write 1 keeps flag");
      wr(0, 8'h03);
      check("R11", int'(irq_o), 0, "write 0 clears flag");

      phase = "R8";
      ticks(11);
      check("R8", int'(irq_o), 0, "reload before match");
      ticks(1);
      check("R8", int'(irq_o), 1, "reload match");

      phase = "R11";
      wr(0, 8'h03);
      ticks(11);
      cyc(1, 1, 0, 8'h03);
      check("R11", int'(irq_o), 1, "set wins over clear");

      // R9: one-shot
      phase = "R9";
      wr(0, 8'h03);
      wr(0, 8'h01);
      wr(1, 2); wr(0, 8'h0B);
      ticks(8);
      check("R9", int'(irq_o), 1, "one-shot match");
      wr(0, 8'h0B);
      ticks(16);
      check("R9", int'(irq_o), 0, "one-shot stays stopped");

      // R10: interval enable
      phase = "R10";
      wr(0, 8'h09); wr(0, 8'h0B);
      ticks(7);
      check("R10", int'(irq_o), 0, "rearm before match");
      ticks(1);
      check("R10", int'(irq_o), 1, "rearm match");
      wr(0, 8'h03);
      ticks(4);
      wr(0, 8'h01); wr(0, 8'h03);
      ticks(7);
      check("R10", int'(irq_o), 0, "count restarted from zero");
      ticks(1);
      check("R10", int'(irq_o), 1, "match after restart");

      phase = "R11";
      wr(0, 8'h03);
      wr(0, 8'h07);
      check("R11", int'(irq_o), 0, "write 1 does not set flag");

      // R7: interval 0 means 256
      phase = "R7";
      wr(0, 8'h01); wr(1, 0); wr(0, 8'h03);
      ticks(1023);
      check("R7", int'(irq_o), 0, "interval 0 before 256 steps");
      ticks(1);
      check("R7", int'(irq_o), 1, "interval 0 at 256 steps");

      // R7: second, minute and hour units
      wr(0, 8'h01); wr(1, 1); wr(2, 126); wr(0, 8'h13);
      ticks(4);
      check("R7", int'(irq_o), 0, "seconds unit before wrap");
      ticks(4);
      check("R7", int'(irq_o), 1, "seconds unit at wrap");
      wr(0, 8'h01); wr(3, 59); wr(2, 127); wr(0, 8'h23);
      ticks(4);
      check("R7", int'(irq_o), 1, "minutes unit event");
      wr(0, 8'h01); wr(4, 59); wr(3, 59); wr(2, 127); wr(0, 8'h33);
      ticks(4);
      check("R7", int'(irq_o), 1, "hours unit event");

      phase = "R6";
      wr(0, 8'hFF);
      check("R6", int'(ctl_o), 32'h7F, "ctl field readback");

      // mixed random stimulus
      phase = "R7 random";
      for (int i = 0; i < 4000; i++) begin
         int r, s, d;
         r = int'($urandom);
         s = 0; d = 0;
         if (((r >> 4) & 15) == 0) begin
            s = int'($urandom % 8);
            d = int'($urandom % 256);
            if (s == 0) d = (d & 8'hFE) | (((r >> 8) & 3) != 0 ? 1 : 0);
            if (s == 1) d = 1 + int'($urandom % 6);
            if (s >= 2 && ((r >> 10) & 1) == 1) d = d % 24;
            cyc(r[0], 1, s, d);
         end else begin
            cyc(r[0], 0, 0, 0);
         end
      end

      if (!over) begin
         over = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule